// File: doc/BRIEF.md
# Multimode Acceleration Sample Buffer

This block holds three-axis acceleration sample sets in an internal memory and hands them back one byte per read strobe. Each accepted set is stored as 3 bytes at 8-bit resolution (the upper byte of each axis) or as 6 bytes at 16-bit resolution. A set is only counted, dropped or overwritten as a whole.

A 2-bit mode input picks how the buffer behaves when it fills, around a trigger, and which end reads come from. A 10-bit threshold drives a watermark flag, and the occupancy is reported as an 11-bit set count split into two fields. A clear strobe, or any change of the resolution input, empties the buffer. The block feeds an interrupt controller through its watermark, full and trigger-status outputs.

Top module: `accel_set_buffer`

## Requirements
- R1: Byte order per set. At 8-bit resolution (`hires`=0) a set reads back as X[15:8], Y[15:8], Z[15:8]. At 16-bit resolution it reads back as X[7:0], X[15:8], Y[7:0], Y[15:8], Z[7:0], Z[15:8]. `rd_data` holds the byte for a strobe from the clock edge that samples `rd_stb` onward.
- R2: Capacity is CAP_LO sets (681) at 8-bit resolution and CAP_HI sets (339) at 16-bit resolution. `full_flag` is 1 exactly when the level equals the capacity in force.
- R3: In mode 2'b00, a sample that arrives while full is discarded. A read that consumes the last byte of a set in the same cycle frees the slot, and that sample is then stored.
- R4: In mode 2'b01, a sample that arrives while full replaces the oldest set. If the oldest set was partly read, it is discarded whole, and the next read returns byte 0 of the new oldest set.
- R5: In mode 2'b10, before a trigger, only the most recent L sets are kept. L is the threshold, with 0 taken as 1 and values above the capacity clamped to the capacity. A `trig` pulse while enabled sets `trig_stat`, which stays set. From then on the buffer fills to capacity and discards further samples.
- R6: In mode 2'b11, storage behaves as in mode 2'b01, but reads start from the newest set. A sample stored while a set is partly read restarts reading at byte 0 of the new newest set.
- R7: The level is the number of whole stored sets, reported as `lvl_lo` = level[7:0] and `lvl_hi` = level[10:8]. It drops by one when the last byte of a set is read.
- R8: The threshold is {`thr_hi`,`thr_lo`}. When the threshold is nonzero, `wm_flag` is 1 while level ≥ threshold. It falls by itself once reads bring the level below the threshold.
- R9: A `clr_wr` strobe sets the level to 0 and clears `trig_stat` at the next edge. It wins over a sample in the same cycle.
- R10: A change of `hires` empties the buffer in the same way as a clear.
- R11: With `ena`=0, samples and `trig` are ignored, and reads still work.
- R12: A read strobe on an empty buffer returns 0x00 and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ena | input | 1 | Collection enable |
| hires | input | 1 | 1 = 16-bit sets, 0 = 8-bit sets |
| mode | input | 2 | 00 stop, 01 overwrite, 10 pre-trigger, 11 newest-first |
| thr_lo | input | 8 | Threshold bits 7:0 |
| thr_hi | input | 2 | Threshold bits 9:8 |
| clr_wr | input | 1 | Clear strobe |
| smp_vld | input | 1 | Sample set valid |
| smp_x | input | 16 | X sample |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| trig | input | 1 | Trigger event |
| rd_stb | input | 1 | Read one byte |
| rd_data | output | 8 | Byte returned by the last read strobe |
| lvl_lo | output | 8 | Level bits 7:0 |
| lvl_hi | output | 3 | Level bits 10:8 |
| trig_stat | output | 1 | Trigger seen since last clear |
| wm_flag | output | 1 | Level at or above threshold |
| full_flag | output | 1 | Level equals capacity |

## Verification
A sample arrival and a read can land in the same cycle, and the outcome depends on whether that read finishes a set. The bench fills the buffer at 16-bit resolution in stop mode. It then raises a sample together with the strobe that reads the final byte of the oldest set, and expects the level to stay at capacity, because the freed slot takes the new set. In overwrite mode, a sample is pushed while the oldest set is half read, and the next byte read must be byte 0 of the following set. A clear is also raised together with a sample, and the level must come out as zero.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        SB_STOP   = 2'b00,
        SB_STREAM = 2'b01,
        SB_TRIG   = 2'b10,
        SB_NEWEST = 2'b11
    } sb_mode_e;

    typedef struct packed {
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] z;
    } sb_set_t;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sb_ring_ctrl.sv
module sb_ring_ctrl
    import sb_pkg::*;
#(
    parameter int CAP_LO = 681,
    parameter int CAP_HI = 339,
    parameter int SW     = 10,
    parameter int LW     = 11,
    parameter int TW     = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_all,
    input  logic          hires,
    input  sb_mode_e      mode,
    input  logic          ena,
    input  logic          trig,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [TW-1:0] thr,
    output logic [LW-1:0] cnt,
    output logic [LW-1:0] cap,
    output logic [SW-1:0] rd_slot,
    output logic [2:0]    rd_off,
    output logic          rd_act,
    output logic          wr_en,
    output logic [SW-1:0] wr_slot,
    output logic          trig_seen
);

    logic [SW-1:0] head_q, head1, head_n;
    logic [LW-1:0] cnt_q, cnt1, cnt_n, pre_lim, thr_ext;
    logic [2:0]    off_q, off_n, last_off;
    logic          trig_q, rd_done, filo, drop;

    function automatic logic [SW-1:0] slot_add(input logic [SW-1:0] s,
                                               input logic [LW-1:0] n,
                                               input logic [LW-1:0] c);
        logic [LW:0] sum;
        sum = {{(LW+1-SW){1'b0}}, s} + {1'b0, n};
        if (sum >= {1'b0, c}) sum = sum - {1'b0, c};
        return sum[SW-1:0];
    endfunction

    always_comb begin
        cap      = hires ? LW'(CAP_HI) : LW'(CAP_LO);
        last_off = hires ? 3'd5 : 3'd2;
        filo     = (mode == SB_NEWEST);
        thr_ext  = LW'(thr);
        pre_lim  = (thr == '0) ? LW'(1) : ((thr_ext > cap) ? cap : thr_ext);

        rd_act  = rd_req && (cnt_q != '0);
        rd_done = rd_act && (off_q == last_off);
        rd_slot = filo ? slot_add(head_q, cnt_q - LW'(1), cap) : head_q;

        head1 = (rd_done && !filo) ? slot_add(head_q, LW'(1), cap) : head_q;
        cnt1  = rd_done ? cnt_q - LW'(1) : cnt_q;

        wr_en = 1'b0;
        drop  = 1'b0;
        unique case (mode)
            SB_STREAM, SB_NEWEST: begin
                wr_en = wr_req;
                drop  = wr_req && (cnt1 == cap);
            end
            SB_TRIG: begin
                if (trig_q) begin
                    wr_en = wr_req && (cnt1 < cap);
                end else begin
                    wr_en = wr_req;
                    drop  = wr_req && (cnt1 >= pre_lim);
                end
            end
            default: wr_en = wr_req && (cnt1 < cap);
        endcase

        wr_slot = slot_add(head1, cnt1, cap);
        head_n  = drop ? slot_add(head1, LW'(1), cap) : head1;
        cnt_n   = (wr_en && !drop) ? cnt1 + LW'(1) : cnt1;

        off_n = off_q;
        if (rd_done)     off_n = 3'd0;
        else if (rd_act) off_n = off_q + 3'd1;
        if (wr_en && (filo || drop)) off_n = 3'd0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            head_q <= '0;
            cnt_q  <= '0;
            off_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            head_q <= head_n;
            cnt_q  <= cnt_n;
            off_q  <= off_n;
            trig_q <= trig_q | ((mode == SB_TRIG) && ena && trig);
        end
    end

    assign cnt       = cnt_q;
    assign rd_off    = off_q;
    assign trig_seen = trig_q;

endmodule

// File: rtl/sb_set_store.sv
module sb_set_store
    import sb_pkg::*;
#(
    parameter int DEPTH = 681,
    parameter int SW    = 10,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hires,
    input  logic          we,
    input  logic [SW-1:0] wslot,
    input  sb_set_t       wset,
    input  logic          rd_req,
    input  logic          rd_act,
    input  logic [SW-1:0] rslot,
    input  logic [2:0]    roff,
    output logic [7:0]    rdata
);

    logic [23:0]   mem [DEPTH];
    logic [AW-1:0] wa0, wa1, ra;
    logic [23:0]   w_lo, w_hi0, w_hi1;
    logic          hi_half;
    logic [1:0]    lane;

    always_comb begin
        wa0   = hires ? AW'({wslot, 1'b0}) : AW'(wslot);
        wa1   = wa0 + AW'(1);
        w_lo  = {wset.z[15:8], wset.y[15:8], wset.x[15:8]};
        w_hi0 = {wset.y[7:0],  wset.x[15:8], wset.x[7:0]};
        w_hi1 = {wset.z[15:8], wset.z[7:0],  wset.y[15:8]};
        hi_half = hires && (roff >= 3'd3);
        lane    = hi_half ? 2'(roff - 3'd3) : roff[1:0];
        ra      = hires ? AW'({rslot, 1'b0}) + AW'(hi_half) : AW'(rslot);
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa0] <= hires ? w_hi0 : w_lo;
            if (hires) mem[wa1] <= w_hi1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= 8'h00;
        else if (rd_req) rdata <= rd_act ? mem[ra][{lane, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/accel_set_buffer.sv
module accel_set_buffer
    import sb_pkg::*;
#(
    parameter int CAP_LO = 681,
    parameter int CAP_HI = 339,
    parameter int LVL_W  = 11,
    parameter int THR_W  = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ena,
    input  logic        hires,
    input  logic [1:0]  mode,
    input  logic [7:0]  thr_lo,
    input  logic [1:0]  thr_hi,
    input  logic        clr_wr,
    input  logic        smp_vld,
    input  logic [15:0] smp_x,
    input  logic [15:0] smp_y,
    input  logic [15:0] smp_z,
    input  logic        trig,
    input  logic        rd_stb,
    output logic [7:0]  rd_data,
    output logic [7:0]  lvl_lo,
    output logic [2:0]  lvl_hi,
    output logic        trig_stat,
    output logic        wm_flag,
    output logic        full_flag
);

    localparam int SW    = $clog2(maxi(CAP_LO, CAP_HI));
    localparam int DEPTH = maxi(CAP_LO, 2 * CAP_HI);
    localparam int AW    = $clog2(DEPTH);

    logic             res_q, clr_all, rd_act, wr_en;
    logic [LVL_W-1:0] cnt, cap;
    logic [SW-1:0]    rd_slot, wr_slot;
    logic [2:0]       rd_off;
    logic [THR_W-1:0] thr;
    sb_set_t          in_set;

    always_ff @(posedge clk) begin
        if (rst) res_q <= 1'b0;
        else     res_q <= hires;
    end

    assign clr_all = clr_wr || (hires != res_q);
    assign thr     = THR_W'({thr_hi, thr_lo});
    assign in_set  = '{x: smp_x, y: smp_y, z: smp_z};

    sb_ring_ctrl #(
        .CAP_LO(CAP_LO), .CAP_HI(CAP_HI), .SW(SW), .LW(LVL_W), .TW(THR_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .clr_all(clr_all), .hires(hires),
        .mode(sb_mode_e'(mode)), .ena(ena), .trig(trig),
        .wr_req(smp_vld && ena), .rd_req(rd_stb), .thr(thr),
        .cnt(cnt), .cap(cap), .rd_slot(rd_slot), .rd_off(rd_off),
        .rd_act(rd_act), .wr_en(wr_en), .wr_slot(wr_slot), .trig_seen(trig_stat)
    );

    sb_set_store #(.DEPTH(DEPTH), .SW(SW), .AW(AW)) u_store (
        .clk(clk), .rst(rst), .hires(hires), .we(wr_en && !clr_all),
        .wslot(wr_slot), .wset(in_set), .rd_req(rd_stb), .rd_act(rd_act),
        .rslot(rd_slot), .roff(rd_off), .rdata(rd_data)
    );

    assign lvl_lo    = cnt[7:0];
    assign lvl_hi    = 3'(cnt >> 8);
    assign wm_flag   = (thr != '0) && (cnt >= LVL_W'(thr));
    assign full_flag = (cnt == cap);

endmodule

// File: rtl/accel_set_buffer_chk.sv
module accel_set_buffer_chk #(
    parameter int CAP_LO = 681,
    parameter int CAP_HI = 339
) (
    input logic        clk,
    input logic        rst,
    input logic        clr_all,
    input logic        ena,
    input logic        hires,
    input logic [1:0]  mode,
    input logic        rd_stb,
    input logic [10:0] lvl,
    input logic [9:0]  thr,
    input logic        wm_flag,
    input logic        full_flag,
    input logic        trig_stat
);

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (lvl == 11'd0 && !trig_stat));

    a_r5_trig_sticky: assert property (@(posedge clk) disable iff (rst)
        (trig_stat && !clr_all) |=> trig_stat);

    a_r7_level_step: assert property (@(posedge clk) disable iff (rst)
        !clr_all |=> ({1'b0, lvl} <= {1'b0, $past(lvl)} + 12'd1) &&
                     ({1'b0, lvl} + 12'd1 >= {1'b0, $past(lvl)}));

    a_r3_stop_full_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && full_flag && !rd_stb && !clr_all) |=> $stable(lvl));

    a_r11_disabled_no_growth: assert property (@(posedge clk) disable iff (rst)
        (!ena && !clr_all) |=> (lvl <= $past(lvl)));

    a_r2_level_within_cap: assert property (@(posedge clk) disable iff (rst)
        !clr_all |-> (lvl <= (hires ? 11'(CAP_HI) : 11'(CAP_LO))));

    a_r8_wm_rises_on_growth: assert property (@(posedge clk) disable iff (rst)
        ($rose(wm_flag) && $stable(thr)) |-> (lvl > $past(lvl)));

endmodule

bind accel_set_buffer accel_set_buffer_chk #(.CAP_LO(CAP_LO), .CAP_HI(CAP_HI)) u_chk (
    .clk(clk), .rst(rst), .clr_all(clr_all), .ena(ena), .hires(hires),
    .mode(mode), .rd_stb(rd_stb), .lvl({lvl_hi, lvl_lo}), .thr({thr_hi, thr_lo}),
    .wm_flag(wm_flag), .full_flag(full_flag), .trig_stat(trig_stat)
);

// File: tb/accel_set_buffer_tb.sv
module accel_set_buffer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ena = 1'b1, hires = 1'b0, clr_wr = 1'b0, smp_vld = 1'b0;
    logic        trig = 1'b0, rd_stb = 1'b0;
    logic [1:0]  mode = 2'b00, thr_hi = 2'b00;
    logic [7:0]  thr_lo = 8'h00;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [7:0]  rd_data, lvl_lo;
    logic [2:0]  lvl_hi;
    logic        trig_stat, wm_flag, full_flag;
    int          nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    accel_set_buffer u_dut (
        .clk(clk), .rst(rst), .ena(ena), .hires(hires), .mode(mode),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .clr_wr(clr_wr), .smp_vld(smp_vld),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .trig(trig), .rd_stb(rd_stb),
        .rd_data(rd_data), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .trig_stat(trig_stat),
        .wm_flag(wm_flag), .full_flag(full_flag)
    );

    localparam logic [47:0] TAB [6] = '{
        48'h12A1_34B2_56C3, 48'hFE01_DC02_BA03, 48'h0F10_1F20_2F30,
        48'h8877_6655_4433, 48'h0102_0304_0506, 48'hE0E1_D0D1_C0C1
    };

    function automatic int level();
        return {lvl_hi, lvl_lo};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        smp_x = x; smp_y = y; smp_z = z; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic wr_idx(input int i);
        wr_raw({8'(i), 8'(i + 1)}, {8'(i + 2), 8'(i + 3)}, {8'(i + 4), 8'(i + 5)});
    endtask

    task automatic rd_one(output logic [7:0] b);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        b = rd_data;
    endtask

    task automatic clear();
        clr_wr = 1'b1;
        @(negedge clk);
        clr_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset level", level(), 0);
        chk("R8 reset wm", wm_flag, 0);
        chk("R2 reset full", full_flag, 0);
        chk("R5 reset trig", trig_stat, 0);

        // R1 8-bit table walk
        for (int k = 0; k < 6; k++) wr_raw(TAB[k][47:32], TAB[k][31:16], TAB[k][15:0]);
        chk("R7 six sets", level(), 6);
        for (int k = 0; k < 18; k++) begin
            rd_one(b);
            chk("R1 lo byte", b, TAB[k / 3][47 - 16 * (k % 3) -: 8]);
        end
        chk("R7 drained", level(), 0);

        // R10 resolution change empties
        wr_idx(1); wr_idx(2);
        hires = 1'b1; @(negedge clk);
        chk("R10 hires change empties", level(), 0);

        // R1 16-bit order
        wr_raw(TAB[0][47:32], TAB[0][31:16], TAB[0][15:0]);
        wr_raw(TAB[1][47:32], TAB[1][31:16], TAB[1][15:0]);
        for (int k = 0; k < 12; k++) begin
            rd_one(b);
            chk("R1 hi byte", b, TAB[k / 6][47 - 16 * ((k % 6) / 2) - 8 * (1 - k % 2) -: 8]);
        end

        // R2 / R3 16-bit capacity, stop mode
        for (int i = 0; i < 340; i++) wr_idx(i);
        chk("R2 hi capacity", level(), 339);
        chk("R2 full flag", full_flag, 1);
        for (int k = 0; k < 6; k++) rd_one(b);
        chk("R3 oldest kept", b, 4);
        wr_idx(50);
        chk("R3 refill", level(), 339);
        for (int k = 0; k < 5; k++) rd_one(b);
        smp_vld = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0; rd_stb = 1'b0;
        chk("R3 same-cycle byte", rd_data, 5);
        chk("R3 same-cycle write kept", level(), 339);
        clr_wr = 1'b1; smp_vld = 1'b1;
        @(negedge clk);
        clr_wr = 1'b0; smp_vld = 1'b0;
        chk("R9 clear beats write", level(), 0);

        // R2 8-bit capacity
        hires = 1'b0; @(negedge clk);
        for (int i = 0; i < 682; i++) wr_idx(i);
        chk("R2 lo capacity", level(), 681);

        // R4 streaming overwrite
        clear(); mode = 2'b01;
        for (int i = 0; i < 682; i++) wr_idx(i);
        rd_one(b);
        chk("R4 oldest dropped", b, 1);
        wr_idx(200);
        rd_one(b);
        chk("R4 partial set discarded whole", b, 2);
        chk("R4 level at cap", level(), 681);

        // R6 newest first
        clear(); mode = 2'b11;
        wr_idx(10); wr_idx(20); wr_idx(30);
        rd_one(b); chk("R6 newest X", b, 30);
        rd_one(b); chk("R6 newest Y", b, 32);
        rd_one(b); chk("R6 newest Z", b, 34);
        chk("R7 filo level", level(), 2);
        rd_one(b); chk("R6 next newest", b, 20);
        wr_idx(40);
        rd_one(b); chk("R6 restart on write", b, 40);

        // R8 watermark
        clear(); mode = 2'b00; thr_lo = 8'd3;
        wr_idx(1); wr_idx(2);
        chk("R8 below thr", wm_flag, 0);
        wr_idx(3);
        chk("R8 at thr", wm_flag, 1);
        for (int k = 0; k < 3; k++) rd_one(b);
        chk("R8 auto clear", wm_flag, 0);
        clear(); thr_lo = 8'd0; thr_hi = 2'd1;
        for (int i = 0; i < 255; i++) wr_idx(i);
        chk("R8 hi bits below", wm_flag, 0);
        wr_idx(9);
        chk("R8 hi bits reached", wm_flag, 1);

        // R5 pre-trigger capture
        clear(); mode = 2'b10; thr_hi = 2'd0; thr_lo = 8'd4;
        for (int i = 0; i < 10; i++) wr_idx(i);
        chk("R5 pre-trigger depth", level(), 4);
        chk("R5 no trig yet", trig_stat, 0);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        chk("R5 trig latched", trig_stat, 1);
        for (int i = 10; i < 688; i++) wr_idx(i);
        chk("R5 fill to cap", level(), 681);
        chk("R5 trig sticky", trig_stat, 1);
        rd_one(b);
        chk("R5 history start", b, 6);
        clear();
        chk("R9 clear trig", trig_stat, 0);
        chk("R9 clear level", level(), 0);

        // R12 empty read
        rd_one(b);
        chk("R12 empty read data", b, 0);
        chk("R12 empty read level", level(), 0);

        // R5 zero threshold keeps one
        thr_lo = 8'd0;
        wr_idx(7); wr_idx(8); wr_idx(9);
        chk("R5 thr zero depth", level(), 1);
        rd_one(b);
        chk("R5 thr zero newest kept", b, 9);

        // R11 disable
        clear(); ena = 1'b0;
        wr_idx(1); wr_idx(2);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        chk("R11 samples ignored", level(), 0);
        chk("R11 trig ignored", trig_stat, 0);
        ena = 1'b1;

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule